// File: doc/BRIEF.md
# Iterative Effective Address Resolver

This block turns a 24-bit single-address instruction word into the final 15-bit operand address. Each address word carries its own index and indirect flags, so resolution can pass through a chain of memory words. Any word in the chain may add the index register and then point to another word. The block reads those words through a request/valid port to memory. It reports the final address, the number of indirect fetches it made, and a fault when a chain runs past a configured depth.

Word bits are numbered 0 (most significant) to 23. In the port vectors, word bit 0 is `[23]`, word bit 1 is `[22]`, word bit 2 is `[21]`, and the address field (word bits 9 to 23) is `[14:0]`. The calling logic pulses `start` with the instruction and index register. It waits for the one-cycle `done` pulse and then reads `ea`, `levels` and `fault`. These outputs hold until the next resolution completes.

Top module: `ea_chain_resolver`

## Requirements
- R1: After reset, `done`, `mem_req`, `fault`, `levels` and `ea` are all zero.
- R2: `instr[23]` is the indirect flag, `instr[22]` the index flag, `instr[21]` the index-suppress bit and `instr[14:0]` the address. When `start` is accepted with `instr[23]` clear, `done` is high in the next cycle with the computed address on `ea`, `levels` equal to 0 and no memory request.
- R3: With the index flag active, `xr[14:0]` is added to the address field modulo 2^15; a carry out is dropped and `xr[23:15]` has no effect.
- R4: `instr[21]` = 1 disables indexing for the instruction word only; bit `[21]` of a fetched word has no effect on that word's indexing.
- R5: With the indirect flag set, the block reads memory at the indexed address. `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is seen, and exactly one read is made per level.
- R6: Each fetched word is decoded with its own `[23]` indirect flag, its own `[22]` index flag and its own `[14:0]` address. Resolution continues until a word with `[23]` clear is reached, and the address formed from that word is `ea`.
- R7: `levels` equals the number of indirect words fetched for the resolution.
- R8: If the word returned by fetch number MAX_DEPTH still has its indirect flag set, the block stops with `done` and `fault` high and `levels` = MAX_DEPTH. `ea` then holds the address that would have been fetched next. A chain that ends exactly at fetch MAX_DEPTH finishes without a fault.
- R9: A `start` pulse while a resolution is in progress is ignored and does not change its result.
- R10: `done` lasts one cycle and is never high together with `mem_req`. `ea`, `levels` and `fault` hold their values after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `instr` when idle |
| instr | input | 24 | Instruction word |
| xr | input | 24 | Index register; low 15 bits used |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Read address |
| mem_valid | input | 1 | Read data is on `mem_data` this cycle |
| mem_data | input | 24 | Fetched word |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 15 | Resolved effective address |
| levels | output | clog2(MAX_DEPTH+1) | Indirect fetches made |
| fault | output | 1 | Depth limit reached |

## Verification
Directed cases cover the following:
- direct addresses, which separate the no-fetch path from the fetch path;
- a wrap past 2^15, which exposes adder width and ignored index-register bits;
- suppress-bit words at instruction level and at fetched level, which tell the two decode contexts apart;
- a two-level chain with flags on every word, which confirms that indexing precedes each fetch;
- chains of exactly MAX_DEPTH and MAX_DEPTH+1 fetches plus a self-loop, which pin the fault boundary.

Random chains of varying length use random flags and random memory latency, and they occasionally collide into loops. Each result is compared with a bench walk of the same memory. The number of reads served is checked against `levels`. A stray `start` issued mid-chain shows whether busy input is ignored.

// File: rtl/ea_chain_pkg.sv
package ea_chain_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 15;
  localparam int IND_POS = WORD_W - 1;
  localparam int IDX_POS = WORD_W - 2;
  localparam int SUP_POS = WORD_W - 3;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } res_state_t;
endpackage

// File: rtl/ea_step_calc.sv
module ea_step_calc
  import ea_chain_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic [WW-1:0] word,
  input  logic [AW-1:0] xr_low,
  input  logic          honor_sup,
  output logic [AW-1:0] next_addr,
  output logic          indirect
);
  localparam int IND_B = WW - 1;
  localparam int IDX_B = WW - 2;
  localparam int SUP_B = WW - 3;

  logic          use_idx;
  logic          mid_unused;

  assign mid_unused = ^word[SUP_B-1:AW];
  assign use_idx    = word[IDX_B] & ~(honor_sup & word[SUP_B]);
  assign next_addr  = word[AW-1:0] + (use_idx ? xr_low : {AW{1'b0}});
  assign indirect   = word[IND_B];
endmodule

// File: rtl/ea_level_ctr.sv
module ea_level_ctr #(
  parameter int MAX_DEPTH = 64,
  localparam int LW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [LW-1:0] cnt_next,
  output logic          last_allowed
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign cnt_next     = cnt + 1'b1;
  assign last_allowed = (cnt == LW'(MAX_DEPTH - 1));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(MAX_DEPTH));
endmodule

// File: rtl/ea_chain_resolver.sv
module ea_chain_resolver
  import ea_chain_pkg::*;
#(
  parameter int MAX_DEPTH = 64,
  localparam int LW = $clog2(MAX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [WORD_W-1:0]   instr,
  input  logic [WORD_W-1:0]   xr,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_valid,
  input  logic [WORD_W-1:0]   mem_data,
  output logic                done,
  output logic [ADDR_W-1:0]   ea,
  output logic [LW-1:0]       levels,
  output logic                fault
);
  res_state_t        state;
  logic [WORD_W-1:0] cur_word;
  logic [ADDR_W-1:0] step_addr;
  logic              step_ind;
  logic [LW-1:0]     lvl_next;
  logic              lvl_last;
  logic              accept;
  logic              got_word;
  logic              xr_unused;

  assign xr_unused = ^xr[WORD_W-1:ADDR_W];
  assign accept    = (state == ST_IDLE) && start;
  assign got_word  = (state == ST_FETCH) && mem_valid;
  assign cur_word  = (state == ST_IDLE) ? instr : mem_data;

  ea_step_calc #(.WW(WORD_W), .AW(ADDR_W)) u_step (
    .word      (cur_word),
    .xr_low    (xr[ADDR_W-1:0]),
    .honor_sup (state == ST_IDLE),
    .next_addr (step_addr),
    .indirect  (step_ind)
  );

  ea_level_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_lvl (
    .clk          (clk),
    .rst          (rst),
    .clr          (accept),
    .inc          (got_word),
    .cnt_next     (lvl_next),
    .last_allowed (lvl_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      ea       <= '0;
      levels   <= '0;
      fault    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (step_ind) begin
          mem_req  <= 1'b1;
          mem_addr <= step_addr;
          state    <= ST_FETCH;
        end else begin
          done   <= 1'b1;
          ea     <= step_addr;
          levels <= '0;
          fault  <= 1'b0;
        end
      end else if (got_word) begin
        if (!step_ind || lvl_last) begin
          mem_req <= 1'b0;
          done    <= 1'b1;
          ea      <= step_addr;
          levels  <= lvl_next;
          fault   <= step_ind;
          state   <= ST_IDLE;
        end else begin
          mem_addr <= step_addr;
        end
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && mem_addr == $past(mem_addr)));

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R10
  req_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_req) |-> done);

  // R8
  fault_depth_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (levels == LW'(MAX_DEPTH)));

  // R2
  direct_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !instr[IND_POS]) |=> (done && !mem_req));
endmodule

// File: tb/sim_ea_chain_resolver.sv
module sim_ea_chain_resolver;
  localparam int MAXD = 8;
  localparam int LW = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [23:0] instr, xr, mem_data;
  logic mem_req, mem_valid, done, fault;
  logic [14:0] mem_addr, ea;
  logic [LW-1:0] levels;

  int checks = 0;
  int fails = 0;
  int served = 0;
  logic [23:0] mem [int unsigned];

  always #10 clk = ~clk;

  ea_chain_resolver #(.MAX_DEPTH(MAXD)) u0 (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .xr(xr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .done(done), .ea(ea), .levels(levels), .fault(fault)
  );

  function automatic logic [23:0] rd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 24'h0;
  endfunction

  function automatic logic [14:0] form(input logic [23:0] w, input logic [23:0] x,
                                       input bit top);
    bit ix;
    ix = w[22] && !(top && w[21]);
    return w[14:0] + (ix ? x[14:0] : 15'h0);
  endfunction

  function automatic void model(input logic [23:0] ins, input logic [23:0] x,
                                output logic [14:0] e_ea, output int e_lv,
                                output bit e_f);
    logic [23:0] w;
    bit ind;
    e_ea = form(ins, x, 1'b1);
    ind = ins[23];
    e_lv = 0;
    e_f = 1'b0;
    while (ind) begin
      w = rd(e_ea);
      e_lv++;
      e_ea = form(w, x, 1'b0);
      ind = w[23];
      if (ind && e_lv == MAXD) begin
        e_f = 1'b1;
        break;
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model with random latency
  initial begin
    int wait_ct;
    mem_valid = 1'b0;
    mem_data = '0;
    wait_ct = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) mem_valid = 1'b0;
      else if (mem_req) begin
        if (wait_ct == 0) begin
          mem_data = rd(mem_addr);
          mem_valid = 1'b1;
          served++;
          wait_ct = $urandom_range(0, 3);
        end else wait_ct--;
      end
    end
  end

  task automatic run(input logic [23:0] ins, input logic [23:0] x, input bit poke,
                     input string tag);
    logic [14:0] e_ea;
    int e_lv, cyc, s0;
    bit e_f;
    model(ins, x, e_ea, e_lv, e_f);
    @(negedge clk);
    instr = ins; xr = x; start = 1'b1; s0 = served;
    @(negedge clk);
    start = 1'b0;
    if (e_lv == 0)
      chk(done == 1'b1 && mem_req == 1'b0, {"R2 direct done ", tag}, {done, mem_req}, 2'b10);
    cyc = 0;
    while (!done && cyc < 4000) begin
      if (poke && cyc == 0) begin
        start = 1'b1;
        instr = ~ins;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(ea == e_ea, {"R6 ea ", tag}, ea, e_ea);
    chk(int'(levels) == e_lv, {"R7 levels ", tag}, levels, e_lv);
    chk(fault == e_f, {"R8 fault ", tag}, fault, e_f);
    chk(served - s0 == e_lv, {"R5 reads ", tag}, served - s0, e_lv);
    if (poke) chk(ea == e_ea, {"R9 busy start ignored ", tag}, ea, e_ea);
    @(negedge clk);
    chk(!done && !mem_req, {"R10 pulse ", tag}, {done, mem_req}, 2'b00);
    chk(ea == e_ea, {"R10 hold ", tag}, ea, e_ea);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; instr = '0; xr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_req && !fault && levels == 0 && ea == 0, "R1 reset",
        {done, mem_req, fault, levels, ea}, 0);

    // R2 direct, no index
    run({1'b0, 1'b0, 7'h11, 15'h1234}, 24'h000007, 1'b0, "R2 plain");
    // R3 index wrap, upper xr ignored
    run({1'b0, 1'b1, 7'h00, 15'h7FFF}, 24'hABC001, 1'b0, "R3 wrap");
    // R4 suppress at instruction level
    run({1'b0, 1'b1, 1'b1, 6'h00, 15'd100}, 24'h000005, 1'b0, "R4 suppressed");
    // R4 suppress bit in fetched word is ignored
    mem.delete();
    mem[10] = {1'b0, 1'b1, 1'b1, 6'h00, 15'd200};
    run({1'b1, 1'b1, 1'b1, 6'h00, 15'd10}, 24'h000003, 1'b0, "R4 fetched");
    chk(ea == 15'd203, "R4 fetched indexed", ea, 15'd203);
    // R6 chain of two levels, flags on every word
    mem.delete();
    mem[15'o1002] = {1'b1, 1'b1, 7'h00, 15'o2000};
    mem[15'o2002] = {1'b0, 1'b0, 7'h00, 15'o500};
    run({1'b1, 1'b1, 7'h00, 15'o1000}, 24'o2, 1'b1, "R6 two-level");
    chk(ea == 15'o500 && levels == 2, "R6 two-level result", {levels, ea}, {4'd2, 15'o500});
    // R8 exactly MAXD fetches, then MAXD+1, then self loop
    mem.delete();
    for (int i = 0; i < MAXD - 1; i++) mem[100 + i] = {1'b1, 1'b0, 7'h00, 15'(101 + i)};
    mem[100 + MAXD - 1] = {1'b0, 1'b0, 7'h00, 15'h0123};
    run({1'b1, 1'b0, 7'h00, 15'd100}, 24'h0, 1'b0, "R8 at limit");
    chk(!fault && levels == MAXD, "R8 no fault at limit", {fault, levels}, MAXD);
    run({1'b1, 1'b0, 7'h00, 15'd99}, 24'h0, 1'b0, "R8 over limit");
    mem[99] = {1'b1, 1'b0, 7'h00, 15'd100};
    run({1'b1, 1'b0, 7'h00, 15'd99}, 24'h0, 1'b0, "R8 over limit b");
    chk(fault == 1'b1, "R8 fault over limit", fault, 1);
    mem.delete();
    mem[5] = {1'b1, 1'b0, 7'h00, 15'd5};
    run({1'b1, 1'b0, 7'h00, 15'd5}, 24'h0, 1'b1, "R8 self loop");

    // random chains
    for (int t = 0; t < 150; t++) begin
      logic [23:0] x, ins, w;
      logic [14:0] a;
      int len;
      mem.delete();
      x = $urandom();
      len = ($urandom_range(0, 9) == 0) ? MAXD + 2 : $urandom_range(0, 4);
      ins = $urandom();
      ins[23] = (len > 0);
      if ($urandom_range(0, 3) == 0) ins[14:0] = 15'h7FF0 + 15'($urandom_range(0, 15));
      a = form(ins, x, 1'b1);
      for (int k = 1; k <= len; k++) begin
        w = $urandom();
        w[23] = (k < len);
        if (!mem.exists(int'(a))) mem[int'(a)] = w;
        a = form(rd(a), x, 1'b0);
      end
      run(ins, x, ins[23] && t[0], "R6 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule